// File: doc/BRIEF.md
# Framed Byte-Serial Link Transmitter

This block takes 104-bit transaction packets from three independent request channels (read response, write and read request) and turns each one into a framed stream of bytes for a point-to-point chip link. It sends one byte per clock. Each packet goes out as a fixed 14-byte frame: a zero lead byte, a five-byte header holding the control mode, destination address, size code and type bits, then eight payload bytes. A frame strobe stays high for the whole packet.

Each channel uses a valid/wait handshake. The block picks one channel at a time by fixed priority. The far end can stall the link with two push-back inputs, one for reads and one for writes. Each push-back input passes through a flop synchronizer before it is used. Push-back only stops new packets from starting. A frame that has begun is always sent in full.

A run of 64-bit writes to consecutive 8-byte addresses can be merged into a burst. In a burst the frame stays high and only the payload bytes of each following write are sent. A configuration input can replace the control-mode field of write and read-request packets.

Top module: `link_pkt_tx`

## Requirements
- R1: Packet fields are access = bit 0, write = bit 1, size code = bits [3:2] (3 means 64-bit), control mode = bits [7:4], destination address = bits [39:8], low data = bits [71:40], source/upper word = bits [103:72]. The header bytes are, in order: byte 0 = 0x00; byte 1 = {control mode, dst[31:28]}; bytes 2..4 = dst[27:20], dst[19:12], dst[11:4]; byte 5 = {dst[3:0], size code, write, access}.
- R2: Bytes 6..9 carry packet bits [71:40], most significant byte first, when the write bit is 1. When the write bit is 0 they carry bits [103:72] instead.
- R3: Bytes 10..13 carry packet bits [103:72], most significant byte first.
- R4: The byte after acceptance is byte 0, sent with the frame strobe rising. The strobe stays high for 14 consecutive bytes. Between two packets that are not burst-merged, the strobe is low for at least one cycle.
- R5: A packet is taken at a rising edge where its access is high and its wait is low. While a frame is in progress, all three waits are high, except in the burst slot described in R9.
- R6: When several channels request in the same idle cycle, the read response is taken first, then the write, then the read request. Only the taken channel sees wait low.
- R7: Each push-back input acts through a two-flop synchronizer. A rise at the input raises the affected waits after the second rising edge. Read push-back stalls only the read-request channel. Write push-back stalls the write and read-response channels.
- R8: Push-back that arrives during a frame does not shorten the frame. All 14 bytes (or the remaining burst bytes) are sent.
- R9: During the final byte of a frame whose packet is a 64-bit write, a 64-bit write on the write channel can be taken immediately. This requires the same control mode and a destination equal to the previous destination plus 8. The strobe then stays high and the stream continues with bytes 6..13 of the new packet.
- R10: A pending read-response request blocks the burst continuation of R9.
- R11: With the override input high, the control-mode field of write and read-request packets is replaced by the configured value, both in byte 1 and in the burst comparison. Read responses keep their own field.
- R12: After reset the strobe and data byte are low and, with no push-back and no requests, all waits are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link byte clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_ctrl_override | input | 1 | Replace control mode on write/read-request packets |
| cfg_ctrl_mode | input | 4 | Control mode used when overriding |
| rr_access | input | 1 | Read-response packet valid |
| rr_packet | input | 104 | Read-response packet |
| rr_wait | output | 1 | Read-response channel stall |
| wr_access | input | 1 | Write packet valid |
| wr_packet | input | 104 | Write packet |
| wr_wait | output | 1 | Write channel stall |
| rd_access | input | 1 | Read-request packet valid |
| rd_packet | input | 104 | Read-request packet |
| rd_wait | output | 1 | Read-request channel stall |
| far_rd_wait | input | 1 | Asynchronous read push-back from the far end |
| far_wr_wait | input | 1 | Asynchronous write push-back from the far end |
| link_frame | output | 1 | Frame strobe |
| link_byte | output | 8 | Serial byte |

## Verification
The hardest case to reach is the one-cycle burst slot. A second write must already be waiting on its channel at the exact cycle the previous frame sends its last byte. A read response may also be pending in that same cycle. The bench reaches this by issuing the next request right after the previous one is taken, so the request sits stalled until that slot. It then counts frame-strobe rises to tell merged packets from separate ones. Push-back arriving mid-frame is brought about the same way: the bench raises it a few bytes into a frame while a further request is waiting.

// File: rtl/link_tx_pkg.sv
package link_tx_pkg;
  localparam int PKT_W      = 104;
  localparam int IDX_W      = 4;
  localparam int LAST_IDX   = 13;
  localparam int BURST_IDX  = 6;
  localparam logic [1:0] SIZE_64 = 2'b11;

  function automatic logic [31:0] dst_of(input logic [PKT_W-1:0] p);
    return p[39:8];
  endfunction

  function automatic logic [3:0] ctrl_of(input logic [PKT_W-1:0] p);
    return p[7:4];
  endfunction

  function automatic logic [PKT_W-1:0] with_ctrl(input logic [PKT_W-1:0] p,
                                                 input logic ovr,
                                                 input logic [3:0] mode);
    logic [PKT_W-1:0] r;
    r = p;
    if (ovr) r[7:4] = mode;
    return r;
  endfunction

  function automatic logic [7:0] frame_byte(input logic [PKT_W-1:0] p,
                                            input logic [IDX_W-1:0] i);
    logic [31:0] lo;
    logic [31:0] hi;
    logic [7:0]  b;
    lo = p[1] ? p[71:40] : p[103:72];
    hi = p[103:72];
    case (i)
      4'd1:    b = {p[7:4], p[39:36]};
      4'd2:    b = p[35:28];
      4'd3:    b = p[27:20];
      4'd4:    b = p[19:12];
      4'd5:    b = {p[11:8], p[3:0]};
      4'd6:    b = lo[31:24];
      4'd7:    b = lo[23:16];
      4'd8:    b = lo[15:8];
      4'd9:    b = lo[7:0];
      4'd10:   b = hi[31:24];
      4'd11:   b = hi[23:16];
      4'd12:   b = hi[15:8];
      4'd13:   b = hi[7:0];
      default: b = 8'h00;
    endcase
    return b;
  endfunction
endpackage

// File: rtl/link_tx_wait_sync.sv
module link_tx_wait_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_n;

  always_comb begin
    sh_n = {sh_q[STAGES-2:0], d};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_n;
  end

  assign q = sh_q[STAGES-1];
endmodule

// File: rtl/link_tx_arb.sv
module link_tx_arb (
  input  logic       idle,
  input  logic       last,
  input  logic       burst_ok,
  input  logic       wr_hold,
  input  logic       rd_hold,
  input  logic [2:0] req,
  output logic [2:0] grant,
  output logic [2:0] stall
);
  logic rr_open;
  logic wr_open;
  logic rd_open;

  always_comb begin
    rr_open = !wr_hold && idle;
    wr_open = !wr_hold && !req[0] && (idle || (last && burst_ok));
    rd_open = !rd_hold && idle && !(!wr_hold && (req[0] || req[1]));
    grant   = {req[2] && rd_open, req[1] && wr_open, req[0] && rr_open};
    stall   = {!rd_open, !wr_open, !rr_open};
  end
endmodule

// File: rtl/link_tx_ser.sv
module link_tx_ser
  import link_tx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [PKT_W-1:0] load_pkt,
  output logic             active,
  output logic             last,
  output logic [PKT_W-1:0] cur_pkt,
  output logic [7:0]       byte_o
);
  logic             act_q, act_n;
  logic [IDX_W-1:0] idx_q, idx_n;
  logic [PKT_W-1:0] pkt_q, pkt_n;
  logic             at_last;

  assign at_last = act_q && (idx_q == IDX_W'(LAST_IDX));

  always_comb begin
    act_n = act_q;
    idx_n = idx_q;
    pkt_n = pkt_q;
    if (load) begin
      pkt_n = load_pkt;
      act_n = 1'b1;
      idx_n = act_q ? IDX_W'(BURST_IDX) : '0;
    end else if (act_q) begin
      if (at_last) act_n = 1'b0;
      else         idx_n = idx_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      idx_q <= '0;
      pkt_q <= '0;
    end else begin
      act_q <= act_n;
      idx_q <= idx_n;
      if (load) pkt_q <= pkt_n;
    end
  end

  assign active  = act_q;
  assign last    = at_last;
  assign cur_pkt = pkt_q;
  assign byte_o  = act_q ? frame_byte(pkt_q, idx_q) : 8'h00;

  AST_NO_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q && !at_last) |=> (act_q && idx_q == $past(idx_q) + 1'b1)); // R8
  AST_LOAD_WHEN_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> (!act_q || at_last)); // R5
  AST_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    act_q |-> (idx_q <= IDX_W'(LAST_IDX))); // R4
endmodule

// File: rtl/link_pkt_tx.sv
module link_pkt_tx
  import link_tx_pkg::*;
#(
  parameter int SYNC_STAGES  = 2,
  parameter int BURST_STRIDE = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_ctrl_override,
  input  logic [3:0]       cfg_ctrl_mode,
  input  logic             rr_access,
  input  logic [PKT_W-1:0] rr_packet,
  output logic             rr_wait,
  input  logic             wr_access,
  input  logic [PKT_W-1:0] wr_packet,
  output logic             wr_wait,
  input  logic             rd_access,
  input  logic [PKT_W-1:0] rd_packet,
  output logic             rd_wait,
  input  logic             far_rd_wait,
  input  logic             far_wr_wait,
  output logic             link_frame,
  output logic [7:0]       link_byte
);
  localparam int N_HOLD = 2;

  logic [N_HOLD-1:0] hold_raw, hold_s;
  logic [2:0]        req, grant, stall;
  logic [PKT_W-1:0]  wr_eff, rd_eff, load_pkt, cur_pkt;
  logic              active, last, burst_ok, load;

  assign hold_raw = {far_rd_wait, far_wr_wait};

  for (genvar g = 0; g < N_HOLD; g++) begin : g_sync
    link_tx_wait_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(hold_raw[g]), .q(hold_s[g]));
  end

  assign wr_eff = with_ctrl(wr_packet, cfg_ctrl_override, cfg_ctrl_mode);
  assign rd_eff = with_ctrl(rd_packet, cfg_ctrl_override, cfg_ctrl_mode);

  always_comb begin
    burst_ok = cur_pkt[1] && (cur_pkt[3:2] == SIZE_64) &&
               wr_eff[1]  && (wr_eff[3:2]  == SIZE_64) &&
               (ctrl_of(wr_eff) == ctrl_of(cur_pkt)) &&
               (dst_of(wr_eff) == dst_of(cur_pkt) + 32'(BURST_STRIDE));
  end

  assign req = {rd_access, wr_access, rr_access};

  link_tx_arb u_arb (
    .idle(!active), .last(last), .burst_ok(burst_ok),
    .wr_hold(hold_s[0]), .rd_hold(hold_s[1]),
    .req(req), .grant(grant), .stall(stall));

  always_comb begin
    unique case (1'b1)
      grant[0]: load_pkt = rr_packet;
      grant[1]: load_pkt = wr_eff;
      default:  load_pkt = rd_eff;
    endcase
  end

  assign load = |grant;

  link_tx_ser u_ser (
    .clk(clk), .rst_n(rst_n), .load(load), .load_pkt(load_pkt),
    .active(active), .last(last), .cur_pkt(cur_pkt), .byte_o(link_byte));

  assign link_frame = active;
  assign rr_wait    = stall[0];
  assign wr_wait    = stall[1];
  assign rd_wait    = stall[2];

  AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant)); // R6
  AST_START_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !link_frame) |=> (link_frame && link_byte == 8'h00)); // R4
  AST_RD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    hold_s[1] |-> rd_wait); // R7
  AST_RR_NO_BURST: assert property (@(posedge clk) disable iff (!rst_n)
    (link_frame && rr_access) |-> wr_wait); // R10
endmodule

// File: tb/test_link_pkt_tx.sv
module test_link_pkt_tx;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cfg_ov = 1'b0;
  logic [3:0]   cfg_mode = 4'h0;
  logic [2:0]   acc = 3'b000;
  logic [103:0] pk [3];
  logic [2:0]   waits;
  logic         far_rd = 1'b0, far_wr = 1'b0;
  logic         link_frame;
  logic [7:0]   link_byte;

  int checks = 0, fails = 0, rises = 0;
  logic [103:0] expq[$];
  logic [103:0] cur;
  int midx = 0;
  logic prev_f = 1'b0;
  logic mon_on = 1'b0;

  always #2 clk = ~clk;

  link_pkt_tx i_link_pkt_tx (
    .clk(clk), .rst_n(rst_n),
    .cfg_ctrl_override(cfg_ov), .cfg_ctrl_mode(cfg_mode),
    .rr_access(acc[0]), .rr_packet(pk[0]), .rr_wait(waits[0]),
    .wr_access(acc[1]), .wr_packet(pk[1]), .wr_wait(waits[1]),
    .rd_access(acc[2]), .rd_packet(pk[2]), .rd_wait(waits[2]),
    .far_rd_wait(far_rd), .far_wr_wait(far_wr),
    .link_frame(link_frame), .link_byte(link_byte));

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_byte(input logic [103:0] p, input int i);
    logic [31:0] lo, hi, dst;
    lo = p[1] ? p[71:40] : p[103:72];
    hi = p[103:72];
    dst = p[39:8];
    if (i == 0) return 8'h00;
    if (i == 1) return {p[7:4], dst[31:28]};
    if (i == 2) return dst[27:20];
    if (i == 3) return dst[19:12];
    if (i == 4) return dst[11:4];
    if (i == 5) return {dst[3:0], p[3:2], p[1], p[0]};
    if (i < 10) return lo[8*(9-i) +: 8];
    return hi[8*(13-i) +: 8];
  endfunction

  // Byte stream monitor
  always @(negedge clk) begin
    if (mon_on) begin
      if (link_frame && !prev_f) begin
        rises++;
        if (expq.size() == 0) chk(0, "R5 unexpected frame", 1, 0);
        else cur = expq.pop_front();
        midx = 0;
      end else if (link_frame && prev_f) begin
        if (midx == 13) begin
          if (expq.size() == 0) chk(0, "R9 unexpected burst", 1, 0);
          else cur = expq.pop_front();
          midx = 6;
        end else midx++;
      end else if (!link_frame && prev_f && midx != 13) begin
        chk(0, "R8 frame cut short", midx, 13);
      end
      if (link_frame) begin
        if (midx == 1)      chk(link_byte == exp_byte(cur, midx), "R1/R11 byte1", link_byte, exp_byte(cur, midx));
        else if (midx < 6)  chk(link_byte == exp_byte(cur, midx), "R1 header", link_byte, exp_byte(cur, midx));
        else if (midx < 10) chk(link_byte == exp_byte(cur, midx), "R2 low word", link_byte, exp_byte(cur, midx));
        else                chk(link_byte == exp_byte(cur, midx), "R3 upper word", link_byte, exp_byte(cur, midx));
      end
      prev_f = link_frame;
    end
  end

  // Acceptor: models the handshake and the expected packet order
  always begin
    logic [2:0] taken;
    @(negedge clk);
    #1;
    taken = acc & ~waits;
    if (taken != 3'b000) begin
      chk($countones(taken) == 1, "R6 single grant", taken, 0);
      for (int c = 0; c < 3; c++) begin
        if (taken[c]) begin
          logic [103:0] e;
          e = pk[c];
          if (cfg_ov && c != 0) e[7:4] = cfg_mode;
          expq.push_back(e);
        end
      end
      @(posedge clk);
      #1;
      acc = acc & ~taken;
    end
  end

  task automatic send(input int ch, input logic [103:0] p);
    @(negedge clk);
    pk[ch]  = p;
    acc[ch] = 1'b1;
    wait (acc[ch] == 1'b0);
  endtask

  task automatic settle();
    repeat (20) @(negedge clk);
  endtask

  function automatic logic [103:0] mk(input logic [31:0] src, input logic [31:0] dat,
                                      input logic [31:0] dst, input logic [3:0] ctl,
                                      input logic [1:0] dm, input logic w);
    return {src, dat, dst, ctl, dm, w, 1'b1};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int r0;
    pk[0] = '0; pk[1] = '0; pk[2] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    chk(link_frame == 1'b0, "R12 frame", link_frame, 0);
    chk(link_byte == 8'h00, "R12 byte", link_byte, 0);
    chk(waits == 3'b000, "R12 waits", waits, 0);
    mon_on = 1'b1;

    // Sweep: every channel, size code, type bit and override setting (R1 R2 R3 R11)
    for (int k = 0; k < 48; k++) begin
      int ch, dm, w, ov;
      ch = k % 3; dm = (k / 3) % 4; w = (k / 12) % 2; ov = k / 24;
      @(negedge clk);
      cfg_ov = ov[0]; cfg_mode = 4'(k * 7 + 3);
      r0 = rises;
      send(ch, mk(32'hA1B2C3D4 + 32'(k) * 32'h01030507, 32'h5E6F7081 ^ (32'(k) << 9),
                  32'h12345678 + 32'(k) * 32'h0F1E2D3C, 4'(k), 2'(dm), w[0]));
      settle();
      chk(rises == r0 + 1, "R4 one frame per packet", rises, r0 + 1);
    end
    cfg_ov = 1'b0;

    // R6 priority with all three requesting at once while idle
    @(negedge clk);
    pk[0] = mk(32'h11, 32'h22, 32'h33, 4'h1, 2'b10, 1'b1);
    pk[1] = mk(32'h44, 32'h55, 32'h66, 4'h2, 2'b10, 1'b1);
    pk[2] = mk(32'h77, 32'h88, 32'h99, 4'h3, 2'b10, 1'b0);
    acc = 3'b111;
    #1;
    chk(waits == 3'b110, "R6 waits at contention", waits, 3'b110);
    wait (acc == 3'b000);
    settle();
    chk(rises >= 3, "R6 all served", rises, 3);

    // R5: waits high while a frame is in progress
    send(1, mk(32'hCAFE0000, 32'hBEEF0001, 32'h00001000, 4'h0, 2'b10, 1'b1));
    @(negedge clk); #1;
    chk(waits == 3'b111, "R5 busy waits", waits, 3'b111);
    settle();

    // R7 synchronizer latency and channel gating
    @(negedge clk); far_wr = 1'b1;
    @(negedge clk); #1;
    chk(waits == 3'b000, "R7 one edge, not yet", waits, 0);
    @(negedge clk); #1;
    chk(waits == 3'b011, "R7 write hold after two edges", waits, 3'b011);
    @(negedge clk); far_wr = 1'b0;
    repeat (3) @(negedge clk);
    far_rd = 1'b1;
    repeat (2) @(negedge clk); #1;
    chk(waits == 3'b100, "R7 read hold", waits, 3'b100);
    r0 = rises;
    pk[2] = mk(32'h1, 32'h2, 32'h3, 4'h4, 2'b00, 1'b0);
    acc[2] = 1'b1;
    send(1, mk(32'h0BADF00D, 32'h00C0FFEE, 32'h00002000, 4'h5, 2'b01, 1'b1));
    settle();
    chk(acc[2] == 1'b1 && rises == r0 + 1, "R7 read held, write passes", {acc[2], 8'(rises - r0)}, 9'h101);
    far_rd = 1'b0;
    wait (acc[2] == 1'b0);
    settle();

    // R8 push-back mid-frame does not cut the frame; new packet held
    r0 = rises;
    send(1, mk(32'h13572468, 32'h24681357, 32'h00003000, 4'h6, 2'b11, 1'b1));
    repeat (3) @(negedge clk);
    far_wr = 1'b1;
    pk[1] = mk(32'h1, 32'h2, 32'h00003008, 4'h6, 2'b11, 1'b1);
    acc[1] = 1'b1;
    repeat (25) @(negedge clk);
    chk(rises == r0 + 1 && acc[1] == 1'b1, "R8 frame done, next held", rises - r0, 1);
    far_wr = 1'b0;
    wait (acc[1] == 1'b0);
    settle();
    chk(rises == r0 + 2, "R8 held packet sent later", rises - r0, 2);

    // R9 burst: three consecutive 64-bit writes, stride 8
    r0 = rises;
    send(1, mk(32'hAAAA0001, 32'hBBBB0001, 32'h80000100, 4'h9, 2'b11, 1'b1));
    send(1, mk(32'hAAAA0002, 32'hBBBB0002, 32'h80000108, 4'h9, 2'b11, 1'b1));
    send(1, mk(32'hAAAA0003, 32'hBBBB0003, 32'h80000110, 4'h9, 2'b11, 1'b1));
    settle();
    chk(rises == r0 + 1, "R9 burst merged", rises - r0, 1);

    // R9 no burst: stride 16, different control mode, 32-bit size
    r0 = rises;
    send(1, mk(32'h1, 32'h2, 32'h80000200, 4'h9, 2'b11, 1'b1));
    send(1, mk(32'h3, 32'h4, 32'h80000210, 4'h9, 2'b11, 1'b1));
    send(1, mk(32'h5, 32'h6, 32'h80000218, 4'h8, 2'b11, 1'b1));
    send(1, mk(32'h7, 32'h8, 32'h80000220, 4'h8, 2'b10, 1'b1));
    settle();
    chk(rises == r0 + 4, "R9 unmatched writes not merged", rises - r0, 4);

    // R11 override unifies control mode so burst is allowed
    r0 = rises;
    @(negedge clk); cfg_ov = 1'b1; cfg_mode = 4'hC;
    send(1, mk(32'h9, 32'hA, 32'h80000300, 4'h1, 2'b11, 1'b1));
    send(1, mk(32'hB, 32'hC, 32'h80000308, 4'h2, 2'b11, 1'b1));
    settle();
    chk(rises == r0 + 1, "R11 override in burst compare", rises - r0, 1);
    cfg_ov = 1'b0;

    // R10 pending read response blocks the burst slot
    r0 = rises;
    send(1, mk(32'hD, 32'hE, 32'h80000400, 4'h3, 2'b11, 1'b1));
    @(negedge clk);
    pk[0] = mk(32'hF0F0F0F0, 32'h0F0F0F0F, 32'h40000000, 4'h7, 2'b10, 1'b1);
    pk[1] = mk(32'hE, 32'hF, 32'h80000408, 4'h3, 2'b11, 1'b1);
    acc[1:0] = 2'b11;
    wait (acc == 3'b000);
    settle();
    chk(rises == r0 + 3, "R10 burst blocked by read response", rises - r0, 3);

    chk(expq.size() == 0, "R4 all packets emitted", expq.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule